// File: doc/BRIEF.md
# Multiplexed-to-Z80 Bus Adapter

This block sits between a processor whose low address byte shares its pins with the data bus and a system bus built around separate memory-request and I/O-request strobes. On every clock it samples the processor's address latch enable, space select (IO/M), read and write strobes, the shared address/data byte and the high address byte. It presents a demultiplexed 16-bit address, registered memory and I/O request strobes, the read and write strobes, and an enable strobe for peripherals that need one.

The request strobes are formed from the read/write strobes, not from the space select line. The space select line stays valid for a whole instruction, so using it alone would assert a request before the address settles. Gating the requests with the strobes, and with the latch enable, means a request only appears once the latched address is stable. I/O transfers also get one automatic wait state. The processor's READY input is pulled low for one clock when an I/O strobe first appears. A READY low from the system bus is passed through, so a slow device can stretch the cycle further. Write data is presented toward the system bus with an output-enable that is active only while a write strobe is low outside the latch phase.

Top module: `mux_bus_bridge`

## Requirements
- R1: The 16-bit address output is loaded with {high byte, shared byte} one clock after any clock edge at which the latch enable is high. It keeps its value across every edge at which the latch enable is low.
- R2: The memory request output (active low) is low one clock after an edge at which IO/M = 0, the latch enable is low, and read or write (or both) is low. It is high otherwise.
- R3: The I/O request output (active low) is low one clock after an edge at which IO/M = 1, the latch enable is low, and read or write is low. It is high otherwise.
- R4: While the latch enable is high at an edge, both request outputs are high after that edge, whatever the strobes do. The two request outputs are never low together.
- R5: The read and write outputs repeat the processor's read and write strobes, delayed by one clock.
- R6: The peripheral enable output is high exactly when the I/O request output is low.
- R7: The first edge at which an I/O request condition (as in R3) is seen, after an edge without one, drives the processor READY output low for exactly one clock. An I/O strobe that is held does not re-trigger it, and memory cycles never trigger it.
- R8: A low system READY input at an edge drives the processor READY output low after that edge.
- R9: The write-data enable is high one clock after an edge at which write is low and the latch enable is low. It is low otherwise. While it is high, the data output carries the shared byte sampled at that edge.
- R10: A synchronous reset clears the address to zero and forces the request and read/write outputs high, the enable outputs low and processor READY high, regardless of other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_ad_i | input | 8 | Shared low address / data byte from the processor |
| cpu_ahi_i | input | 8 | High address byte from the processor |
| cpu_ale_i | input | 1 | Address latch enable |
| cpu_iom_i | input | 1 | Space select: 0 memory, 1 I/O |
| cpu_rd_n_i | input | 1 | Read strobe, active low |
| cpu_wr_n_i | input | 1 | Write strobe, active low |
| cpu_ready_o | output | 1 | READY to the processor, low inserts waits |
| sys_ready_i | input | 1 | READY from the system bus, low requests waits |
| sys_addr_o | output | 16 | Demultiplexed address |
| sys_mreq_n_o | output | 1 | Memory request, active low |
| sys_iorq_n_o | output | 1 | I/O request, active low |
| sys_rd_n_o | output | 1 | Read strobe to the system bus, active low |
| sys_wr_n_o | output | 1 | Write strobe to the system bus, active low |
| sys_en_o | output | 1 | Peripheral enable strobe, active high |
| sys_data_o | output | 8 | Write data toward the system bus |
| sys_data_oe_o | output | 1 | Drive enable for the write data |

## Verification
The assertions take for granted that every input is defined from the first clock of reset. They also assume inputs change only between clock edges, so each registered output reflects exactly the inputs seen at the previous edge. They do not rely on read and write being exclusive, because the request separation comes from IO/M alone. The stimulus drives all inputs at the falling edge and holds reset over the first edges. Besides ordinary processor cycles, it deliberately includes illegal-looking combinations, such as strobes during the latch phase and read with write together, directed and random, so that the gating is exercised without breaking any assumption.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } space_e;

  // Active-low request for one address space: asserts only when a strobe
  // is low, the space select matches and the latch phase is over.
  function automatic logic req_n(input logic rd_n, input logic wr_n,
                                 input logic iom, input space_e want,
                                 input logic ale);
    return (rd_n & wr_n) | (iom != logic'(want)) | ale;
  endfunction

endpackage

// File: rtl/bridge_addr_latch.sv
module bridge_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale,
  input  logic [LO_W-1:0]      lo_i,
  input  logic [HI_W-1:0]      hi_i,
  output logic [LO_W+HI_W-1:0] addr_o
);
  localparam int ADDR_W = LO_W + HI_W;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (ale) addr_q <= {hi_i, lo_i};
  end

  assign addr_o = addr_q;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_o));

endmodule

// File: rtl/bridge_strobe_gen.sv
module bridge_strobe_gen
  import bridge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  logic iom,
  input  logic rd_n,
  input  logic wr_n,
  output logic mreq_n_o,
  output logic iorq_n_o,
  output logic rd_n_o,
  output logic wr_n_o,
  output logic en_o
);
  logic mreq_d, iorq_d;

  always_comb begin
    mreq_d = req_n(rd_n, wr_n, iom, SPACE_MEM, ale);
    iorq_d = req_n(rd_n, wr_n, iom, SPACE_IO, ale);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_n_o <= 1'b1;
      iorq_n_o <= 1'b1;
      rd_n_o   <= 1'b1;
      wr_n_o   <= 1'b1;
      en_o     <= 1'b0;
    end else begin
      mreq_n_o <= mreq_d;
      iorq_n_o <= iorq_d;
      rd_n_o   <= rd_n;
      wr_n_o   <= wr_n;
      en_o     <= ~iorq_d;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mreq_n_o, ~iorq_n_o}));

  // R4
  no_req_in_ale_chk: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n_o || !iorq_n_o) |-> !$past(ale));

  // R2
  mreq_src_chk: assert property (@(posedge clk) disable iff (rst)
    !mreq_n_o |-> (!$past(iom) && !$past(rd_n && wr_n)));

  // R6
  en_src_chk: assert property (@(posedge clk) disable iff (rst)
    en_o |-> ($past(iom) && !$past(ale)));

endmodule

// File: rtl/bridge_io_wait.sv
module bridge_io_wait
  import bridge_pkg::*;
#(
  parameter int WAIT_CLKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  logic iom,
  input  logic rd_n,
  input  logic wr_n,
  input  logic sys_ready,
  output logic cpu_ready_o
);
  localparam int CW = $clog2(WAIT_CLKS + 1);

  logic          io_act, io_prev, first;
  logic [CW-1:0] cnt;

  always_comb begin
    io_act = ~req_n(rd_n, wr_n, iom, SPACE_IO, ale);
    first  = io_act & ~io_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_prev     <= 1'b0;
      cnt         <= '0;
      cpu_ready_o <= 1'b1;
    end else begin
      io_prev <= io_act;
      if (first)          cnt <= CW'(WAIT_CLKS - 1);
      else if (cnt != '0) cnt <= cnt - 1'b1;
      cpu_ready_o <= sys_ready & ~first & (cnt == '0);
    end
  end

  // R7
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (io_act && !io_prev) |=> !cpu_ready_o);

  // R8
  ext_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_ready |=> !cpu_ready_o);

endmodule

// File: rtl/bridge_data_path.sv
module bridge_data_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          wr_n,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      data_o <= ad_i;
      oe_o   <= ~wr_n & ~ale;
    end
  end

  // R9
  oe_src_chk: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> $past(!wr_n && !ale));

endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
  parameter int LO_W      = 8,
  parameter int HI_W      = 8,
  parameter int WAIT_CLKS = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LO_W-1:0]      cpu_ad_i,
  input  logic [HI_W-1:0]      cpu_ahi_i,
  input  logic                 cpu_ale_i,
  input  logic                 cpu_iom_i,
  input  logic                 cpu_rd_n_i,
  input  logic                 cpu_wr_n_i,
  output logic                 cpu_ready_o,
  input  logic                 sys_ready_i,
  output logic [LO_W+HI_W-1:0] sys_addr_o,
  output logic                 sys_mreq_n_o,
  output logic                 sys_iorq_n_o,
  output logic                 sys_rd_n_o,
  output logic                 sys_wr_n_o,
  output logic                 sys_en_o,
  output logic [LO_W-1:0]      sys_data_o,
  output logic                 sys_data_oe_o
);
  localparam int ADDR_W = LO_W + HI_W;

  logic [ADDR_W-1:0] addr_w;

  bridge_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_addr (
    .clk(clk), .rst(rst), .ale(cpu_ale_i),
    .lo_i(cpu_ad_i), .hi_i(cpu_ahi_i), .addr_o(addr_w)
  );

  assign sys_addr_o = addr_w;

  bridge_strobe_gen u_strobe (
    .clk(clk), .rst(rst), .ale(cpu_ale_i), .iom(cpu_iom_i),
    .rd_n(cpu_rd_n_i), .wr_n(cpu_wr_n_i),
    .mreq_n_o(sys_mreq_n_o), .iorq_n_o(sys_iorq_n_o),
    .rd_n_o(sys_rd_n_o), .wr_n_o(sys_wr_n_o), .en_o(sys_en_o)
  );

  bridge_io_wait #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk(clk), .rst(rst), .ale(cpu_ale_i), .iom(cpu_iom_i),
    .rd_n(cpu_rd_n_i), .wr_n(cpu_wr_n_i),
    .sys_ready(sys_ready_i), .cpu_ready_o(cpu_ready_o)
  );

  bridge_data_path #(.DW(LO_W)) u_data (
    .clk(clk), .rst(rst), .ale(cpu_ale_i), .wr_n(cpu_wr_n_i),
    .ad_i(cpu_ad_i), .data_o(sys_data_o), .oe_o(sys_data_oe_o)
  );

endmodule

// File: tb/mux_bus_bridge_test.sv
`timescale 1ns/1ps
module mux_bus_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cpu_ad = '0, cpu_ahi = '0;
  logic        cpu_ale = 1'b0, cpu_iom = 1'b0;
  logic        cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic        sys_ready = 1'b1;
  logic        cpu_ready;
  logic [15:0] sys_addr;
  logic        mreq_n, iorq_n, rd_n_o, wr_n_o, en, oe;
  logic [7:0]  dout;

  always #2 clk = ~clk;

  mux_bus_bridge uut (
    .clk(clk), .rst(rst), .cpu_ad_i(cpu_ad), .cpu_ahi_i(cpu_ahi),
    .cpu_ale_i(cpu_ale), .cpu_iom_i(cpu_iom), .cpu_rd_n_i(cpu_rd_n),
    .cpu_wr_n_i(cpu_wr_n), .cpu_ready_o(cpu_ready), .sys_ready_i(sys_ready),
    .sys_addr_o(sys_addr), .sys_mreq_n_o(mreq_n), .sys_iorq_n_o(iorq_n),
    .sys_rd_n_o(rd_n_o), .sys_wr_n_o(wr_n_o), .sys_en_o(en),
    .sys_data_o(dout), .sys_data_oe_o(oe)
  );

  typedef struct {
    logic [15:0] addr;
    logic        mreq_n, iorq_n, rd_n, wr_n, en, rdy, oe;
    logic [7:0]  dout;
    bit          in_rst, ale_ctx, ext_wait;
  } exp_t;

  exp_t        q[$];
  int          total = 0, fails = 0;
  bit          done = 1'b0;
  logic [15:0] m_addr = '0;
  logic        m_io_prev = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one clock of inputs and queues the outputs expected after the edge.
  task automatic step(input bit r, input logic ale, input logic iom,
                      input logic rd, input logic wr, input logic [7:0] ad,
                      input logic [7:0] hi, input logic rdy);
    exp_t e;
    logic idle, io_act;
    @(negedge clk);
    rst = r; cpu_ale = ale; cpu_iom = iom; cpu_rd_n = rd; cpu_wr_n = wr;
    cpu_ad = ad; cpu_ahi = hi; sys_ready = rdy;
    e.in_rst = r; e.ale_ctx = ale; e.ext_wait = ~rdy;
    if (r) begin
      m_addr = '0; m_io_prev = 1'b0;
      e.addr = '0; e.mreq_n = 1; e.iorq_n = 1; e.rd_n = 1; e.wr_n = 1;
      e.en = 0; e.rdy = 1; e.oe = 0; e.dout = '0;
    end else begin
      if (ale) m_addr = {hi, ad};
      idle     = rd & wr;
      e.addr   = m_addr;
      e.mreq_n = idle | iom | ale;
      e.iorq_n = idle | ~iom | ale;
      e.en     = ~e.iorq_n;
      e.rd_n   = rd; e.wr_n = wr;
      io_act   = ~e.iorq_n;
      e.rdy    = rdy & ~(io_act & ~m_io_prev);
      m_io_prev = io_act;
      e.oe     = ~wr & ~ale;
      e.dout   = ad;
    end
    q.push_back(e);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.in_rst ? "R10 addr" : "R1 addr", int'(sys_addr), int'(e.addr));
        chk(e.in_rst ? "R10 mreq" : (e.ale_ctx ? "R4 mreq" : "R2 mreq"),
            int'(mreq_n), int'(e.mreq_n));
        chk(e.in_rst ? "R10 iorq" : (e.ale_ctx ? "R4 iorq" : "R3 iorq"),
            int'(iorq_n), int'(e.iorq_n));
        chk("R4 exclusive", int'(!mreq_n && !iorq_n), 0);
        chk(e.in_rst ? "R10 rd" : "R5 rd", int'(rd_n_o), int'(e.rd_n));
        chk(e.in_rst ? "R10 wr" : "R5 wr", int'(wr_n_o), int'(e.wr_n));
        chk(e.in_rst ? "R10 en" : "R6 en", int'(en), int'(e.en));
        chk(e.in_rst ? "R10 ready" : (e.ext_wait ? "R8 ready" : "R7 ready"),
            int'(cpu_ready), int'(e.rdy));
        chk(e.in_rst ? "R10 oe" : "R9 oe", int'(oe), int'(e.oe));
        if (e.oe) chk("R9 data", int'(dout), int'(e.dout));
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      report();
    end
  end

  initial begin
    // R10: reset wins over a latch phase and a read strobe
    repeat (3) step(1, 1, 0, 0, 1, 8'h5A, 8'hA5, 1);
    step(0, 0, 0, 1, 1, 8'h00, 8'h00, 1);
    // R1 R2: memory read
    step(0, 1, 0, 1, 1, 8'h34, 8'h12, 1);
    repeat (2) step(0, 0, 0, 0, 1, 8'hEE, 8'h12, 1);
    step(0, 0, 0, 1, 1, 8'hEE, 8'h12, 1);
    // R9: memory write
    step(0, 1, 0, 1, 1, 8'h78, 8'h56, 1);
    repeat (2) step(0, 0, 0, 1, 0, 8'hAB, 8'h56, 1);
    step(0, 0, 0, 1, 1, 8'hAB, 8'h56, 1);
    // R3 R6 R7: I/O read, wait only on first strobe clock
    step(0, 1, 1, 1, 1, 8'h09, 8'h09, 1);
    repeat (3) step(0, 0, 1, 0, 1, 8'h44, 8'h09, 1);
    step(0, 0, 1, 1, 1, 8'h44, 8'h09, 1);
    // R7: back-to-back I/O strobe rearms the wait
    repeat (2) step(0, 0, 1, 0, 1, 8'h44, 8'h09, 1);
    // R8: I/O write stretched by system READY
    step(0, 1, 1, 1, 1, 8'h10, 8'h00, 1);
    step(0, 0, 1, 1, 0, 8'hC3, 8'h00, 1);
    step(0, 0, 1, 1, 0, 8'hC3, 8'h00, 0);
    step(0, 0, 1, 1, 0, 8'hC3, 8'h00, 0);
    step(0, 0, 1, 1, 0, 8'hC3, 8'h00, 1);
    step(0, 0, 1, 1, 1, 8'hC3, 8'h00, 1);
    // R4: strobes during latch phase give no request and no wait
    step(0, 1, 0, 0, 1, 8'h22, 8'h11, 1);
    step(0, 1, 1, 1, 0, 8'h33, 8'h11, 1);
    step(0, 0, 1, 1, 1, 8'h33, 8'h11, 1);
    // R2: read and write together on memory still request
    step(0, 0, 0, 0, 0, 8'h66, 8'h11, 1);
    step(0, 0, 0, 1, 1, 8'h66, 8'h11, 1);
    // R8: memory cycle with READY held low
    step(0, 0, 0, 0, 1, 8'h66, 8'h11, 0);
    step(0, 0, 0, 1, 1, 8'h66, 8'h11, 1);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned v;
      v = $urandom();
      step(0, v[0] & v[1], v[2], v[3], v[4], v[15:8], v[23:16], ~(v[5] & v[6]));
    end
    // R10: reset mid-cycle
    step(1, 0, 1, 0, 1, 8'h77, 8'h77, 1);
    step(0, 0, 0, 1, 1, 8'h00, 8'h00, 1);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    report();
  end

endmodule